// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply Unit

This block is a signed arithmetic datapath that forms the sum of two operands and multiplies it by a third. It computes (a + b) × c on three two's-complement operands of a common width and returns an exact signed result that is two bits wider than twice the operand width, less one (2W+1 bits). The sum is formed one bit wider than the operands, so no input combination can overflow before the multiply.

A single valid strobe qualifies all three operands together. A matching valid strobe marks the cycle in which each result appears. The pipeline has four register stages: operand capture, sum, product and output. This is the layout a hardened multiply-accumulate slice provides, so it maps onto one. A new operand set may be presented on every cycle, and results leave in the order the operands arrived.

The stream is valid-only and has no back-pressure. The unit never stalls, and the consumer must take each result in the cycle its valid strobe is high. Results then hold on the output until the next one arrives.

Top module: `preadd_mul`

## Requirements
- R1: Whenever `out_vld` is high, `out_data` equals (a + b) × c for the operand set that was sampled with it. It is computed exactly, as a 2W+1-bit two's-complement value, with a, b and c read as signed W-bit numbers.
- R2: The sum is formed at W+1 bits.
  - With a = b = c = -2^(W-1), the result is +2^(2W-1).
  - With a = b = 2^(W-1)-1 and c = -2^(W-1), the result is -(2^W-2)·2^(W-1).
- R3: `out_vld` rises exactly 4 rising clock edges after the edge on which `in_vld` was sampled high, counting the sampling edge as the first.
- R4: An operand set is accepted on every cycle with `in_vld` high, including back-to-back cycles. Results appear on consecutive cycles in arrival order.
- R5: A cycle with `in_vld` low yields `out_vld` low 4 edges later. The operands presented on that cycle affect no output.
- R6: While `out_vld` is low, `out_data` keeps the last valid result unchanged, including across a reset.
- R7: `rst` is a synchronous, active-high reset.
  - It drops every operand set in flight.
  - `out_vld` is low in the cycle after any edge that samples `rst` high.
  - `out_vld` stays low until 4 edges after the first valid input that follows the reset.
- R8: R1 to R6 hold unchanged when the unit is built with W = 32, giving a 65-bit result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_vld | input | 1 | Qualifies the three operands in this cycle |
| in_a | input | W | Signed addend a |
| in_b | input | W | Signed addend b |
| in_c | input | W | Signed multiplier c |
| out_data | output | 2W+1 | Signed result (a + b) × c |
| out_vld | output | 1 | High in the cycle a result is presented |

## Verification
The bench builds two copies of the unit side by side: one at the default operand width of 16 and one at width 32. Both run from the same stimulus schedule. The 16-bit copy brings the most negative and most positive operand corners, and the sign of every product, within reach at 33-bit results. The 32-bit copy checks that the widened sum and the 65-bit product stay exact where a 64-bit reference would wrap. Random gaps in the valid strobe, bursts of back-to-back operands, and a reset issued with operands in flight exercise the fixed latency, the hold behaviour and the flushing in both copies.

// File: rtl/preadd_mul_pkg.sv
package preadd_mul_pkg;

  // Register stages from operand capture to the result register.
  localparam int unsigned PIPE_STAGES = 4;

  // Pre-add width: one guard bit so two W-bit signed values never overflow.
  function automatic int unsigned sum_width(input int unsigned w);
    return w + 1;
  endfunction

  // Full product width of a (W+1)-bit by W-bit signed multiply.
  function automatic int unsigned prod_width(input int unsigned w);
    return 2 * w + 1;
  endfunction

endpackage

// File: rtl/preadd_mul_vpipe.sv
module preadd_mul_vpipe #(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_in,
  output logic [DEPTH-1:0] vld_stage
);

  always_ff @(posedge clk) begin
    if (rst) vld_stage[0] <= 1'b0;
    else     vld_stage[0] <= vld_in;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vld_stage[s] <= 1'b0;
      else     vld_stage[s] <= vld_stage[s-1];
    end
  end

  // R7: an edge that samples reset leaves no stage marked valid.
  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld_stage == '0));

endmodule

// File: rtl/preadd_mul_sum.sv
module preadd_mul_sum
  import preadd_mul_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned SW = sum_width(W)
) (
  input  logic                 clk,
  input  logic                 ld_opnd,
  input  logic                 ld_sum,
  input  logic signed [W-1:0]  a_in,
  input  logic signed [W-1:0]  b_in,
  input  logic signed [W-1:0]  c_in,
  output logic signed [SW-1:0] sum_out,
  output logic signed [W-1:0]  c_out
);

  logic signed [W-1:0] a_q, b_q, c_q;

  // Stage 1: operand capture, loaded only for qualified operands.
  always_ff @(posedge clk) begin
    if (ld_opnd) begin
      a_q <= a_in;
      b_q <= b_in;
      c_q <= c_in;
    end
  end

  // Stage 2: sign-extended pre-add; c travels alongside to stay aligned.
  logic signed [SW-1:0] a_ext, b_ext;
  assign a_ext = {a_q[W-1], a_q};
  assign b_ext = {b_q[W-1], b_q};

  always_ff @(posedge clk) begin
    if (ld_sum) begin
      sum_out <= a_ext + b_ext;
      c_out   <= c_q;
    end
  end

endmodule

// File: rtl/preadd_mul_prod.sv
module preadd_mul_prod
  import preadd_mul_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned SW = sum_width(W),
  localparam int unsigned PW = prod_width(W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_prod,
  input  logic                 ld_res,
  input  logic signed [SW-1:0] sum_in,
  input  logic signed [W-1:0]  c_in,
  output logic signed [PW-1:0] res_out
);

  logic signed [PW-1:0] prod_q;

  // Stage 3: full-width signed multiply; operands extend to PW bits.
  always_ff @(posedge clk) begin
    if (ld_prod) prod_q <= sum_in * c_in;
  end

  // Stage 4: result register, holds while no new result arrives.
  always_ff @(posedge clk) begin
    if (ld_res) res_out <= prod_q;
  end

  // R1: a product of two non-zero factors carries the XOR of their signs.
  p_prod_sign_r1: assert property (@(posedge clk) disable iff (rst)
    (ld_prod && (sum_in != '0) && (c_in != '0)) |=>
      (prod_q[PW-1] == ($past(sum_in[SW-1]) ^ $past(c_in[W-1]))));

endmodule

// File: rtl/preadd_mul.sv
module preadd_mul
  import preadd_mul_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned SW = sum_width(W),
  localparam int unsigned PW = prod_width(W),
  localparam int unsigned NS = PIPE_STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [W-1:0]  in_a,
  input  logic signed [W-1:0]  in_b,
  input  logic signed [W-1:0]  in_c,
  output logic signed [PW-1:0] out_data,
  output logic                 out_vld
);

  logic [NS-1:0]        vstage;
  logic [NS-1:0]        ld;
  logic signed [SW-1:0] sum_w;
  logic signed [W-1:0]  c_w;

  preadd_mul_vpipe #(.DEPTH(NS)) u_vpipe (
    .clk       (clk),
    .rst       (rst),
    .vld_in    (in_vld),
    .vld_stage (vstage)
  );

  // Each data stage loads only when the item entering it is valid;
  // reset blocks loads so the result register keeps its value (R6).
  assign ld = {vstage[NS-2:0], in_vld} & {NS{~rst}};

  preadd_mul_sum #(.W(W)) u_sum (
    .clk     (clk),
    .ld_opnd (ld[0]),
    .ld_sum  (ld[1]),
    .a_in    (in_a),
    .b_in    (in_b),
    .c_in    (in_c),
    .sum_out (sum_w),
    .c_out   (c_w)
  );

  preadd_mul_prod #(.W(W)) u_prod (
    .clk     (clk),
    .rst     (rst),
    .ld_prod (ld[2]),
    .ld_res  (ld[3]),
    .sum_in  (sum_w),
    .c_in    (c_w),
    .res_out (out_data)
  );

  assign out_vld = vstage[NS-1];

  // Checker state: edges since reset, saturating at the pipeline depth.
  logic [2:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                    warm_q <= '0;
    else if (warm_q != 3'(NS))  warm_q <= warm_q + 3'd1;
  end

  // R3 / R5: output valid mirrors input valid four edges earlier.
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 3'(NS)) |-> (out_vld == $past(in_vld, 4)));

  // R1: the result matches the operands sampled four edges earlier.
  p_result_r1: assert property (@(posedge clk) disable iff (rst)
    ((warm_q == 3'(NS)) && out_vld) |->
      (out_data == ($signed($past(in_a, 4)) + $signed($past(in_b, 4)))
                   * $signed($past(in_c, 4))));

  // R6: no valid result means the output register did not move.
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((warm_q != 3'd0) && !out_vld) |-> $stable(out_data));

endmodule

// File: tb/preadd_mul_test.sv
module preadd_mul_test;

  typedef struct { logic signed [32:0] v; int t; string tag; } item16_t;
  typedef struct { logic signed [64:0] v; int t; string tag; } item32_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [15:0] a16 = '0, b16 = '0, c16 = '0;
  logic signed [31:0] a32 = '0, b32 = '0, c32 = '0;
  logic signed [32:0] o16;
  logic signed [64:0] o32;
  logic ov16, ov32;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit run = 1'b0;
  item16_t q16[$];
  item32_t q32[$];
  logic signed [32:0] last16;
  logic signed [64:0] last32;
  bit have16 = 1'b0, have32 = 1'b0;

  always #4ns clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  preadd_mul #(.W(16)) uut (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .in_a(a16), .in_b(b16), .in_c(c16),
    .out_data(o16), .out_vld(ov16));

  preadd_mul #(.W(32)) uut_wide (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .in_a(a32), .in_b(b32), .in_c(c32),
    .out_data(o32), .out_vld(ov32));

  task automatic check(bit ok, string req, logic signed [64:0] act, logic signed [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Operand picker biased toward the signed extremes; w is 16 or 32.
  function automatic logic [31:0] pick(int w);
    logic [31:0] u = $urandom;
    case ($urandom % 8)
      0: return (w == 16) ? 32'hFFFF_8000 : 32'h8000_0000;
      1: return (w == 16) ? 32'h0000_7FFF : 32'h7FFF_FFFF;
      2: return '1;
      3: return '0;
      default: return (w == 16) ? {{16{u[15]}}, u[15:0]} : u;
    endcase
  endfunction

  // Driver: presents one cycle of input and queues the expected result.
  task automatic send(bit v, logic [31:0] x16, y16, z16, x32, y32, z32, string tag);
    logic signed [32:0] e16;
    logic signed [64:0] e32;
    @(negedge clk); #1ns;
    in_vld = v;
    a16 = x16[15:0]; b16 = y16[15:0]; c16 = z16[15:0];
    a32 = x32; b32 = y32; c32 = z32;
    if (v) begin
      e16 = (a16 + b16) * c16;
      e32 = (a32 + b32) * c32;
      q16.push_back('{v: e16, t: cyc, tag: tag});
      q32.push_back('{v: e32, t: cyc, tag: tag});
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      send(1'b0, pick(16), pick(16), pick(16), pick(32), pick(32), pick(32), "R5");
  endtask

  // Monitor: every cycle, compare valid and data against the scoreboard.
  always @(negedge clk) begin
    if (run && !rst) begin
      bit e16v, e32v;
      item16_t i16;
      item32_t i32;
      e16v = (q16.size() > 0) && (cyc - q16[0].t == 4);
      e32v = (q32.size() > 0) && (cyc - q32[0].t == 4);
      check(ov16 == e16v, e16v ? "R3 valid" : "R5 no valid", 65'(ov16), 65'(e16v));
      check(ov32 == e32v, e32v ? "R8 R3 valid" : "R8 R5 no valid", 65'(ov32), 65'(e32v));
      if (e16v) begin
        i16 = q16.pop_front();
        if (ov16) begin
          check(o16 == i16.v, i16.tag, o16, i16.v);
          last16 = o16; have16 = 1'b1;
        end
      end else if (!ov16 && have16) check(o16 == last16, "R6 hold", o16, last16);
      if (e32v) begin
        i32 = q32.pop_front();
        if (ov32) begin
          check(o32 == i32.v, {"R8 ", i32.tag}, o32, i32.v);
          last32 = o32; have32 = 1'b1;
        end
      end else if (!ov32 && have32) check(o32 == last32, "R8 R6 hold", o32, last32);
    end
  end

  task automatic do_reset(int n);
    @(negedge clk); #1ns;
    rst = 1'b1; in_vld = 1'b1;
    q16.delete(); q32.delete();
    repeat (n) @(posedge clk);
    @(negedge clk);
    check(!ov16, "R7 cleared", 65'(ov16), 0);
    check(!ov32, "R8 R7 cleared", 65'(ov32), 0);
    #1ns; rst = 1'b0; in_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    do_reset(2);
    run = 1'b1;

    // R2: widened sum at both sign extremes, then mixed corners.
    send(1, 32'hFFFF_8000, 32'hFFFF_8000, 32'hFFFF_8000,
            32'h8000_0000, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
    send(1, 32'h7FFF, 32'h7FFF, 32'hFFFF_8000,
            32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, "R2 max*min");
    send(1, 32'h7FFF, 32'h7FFF, 32'h7FFF,
            32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R2 max*max");
    send(1, '1, 32'h1, 32'h1234, '1, 32'h1, 32'h1234_5678, "R1 zero sum");
    send(1, 32'hFFFF_FFFD, 32'h5, 32'hFFFF_FFF9, 32'hFFFF_FFFD, 32'h5, 32'hFFFF_FFF9, "R1 small");
    idle(6);

    // R4: a back-to-back burst of ten operand sets.
    for (int i = 0; i < 10; i++)
      send(1, pick(16), pick(16), pick(16), pick(32), pick(32), pick(32), "R4 burst");
    idle(3);

    // R5: a valid, junk cycles, then a valid again.
    send(1, 32'h10, 32'h20, 32'h3, 32'h10, 32'h20, 32'h3, "R1 before gap");
    idle(3);
    send(1, 32'hFFFF_FFF0, 32'h4, 32'h2, 32'hFFFF_FFF0, 32'h4, 32'h2, "R5 after gap");
    idle(6);

    // Random operands with random valid gaps.
    for (int i = 0; i < 400; i++)
      send(($urandom % 10) < 7, pick(16), pick(16), pick(16),
           pick(32), pick(32), pick(32), "R1 random");
    idle(6);

    // R7: reset with three operand sets in flight drops them all.
    for (int i = 0; i < 3; i++)
      send(1, pick(16), pick(16), pick(16), pick(32), pick(32), pick(32), "R7 flushed");
    do_reset(1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!ov16, "R7 no stale valid", 65'(ov16), 0);
      check(!ov32, "R8 R7 no stale valid", 65'(ov32), 0);
    end
    send(1, 32'h7, 32'h9, 32'hFFFF_FFFE, 32'h7, 32'h9, 32'hFFFF_FFFE, "R7 after reset");
    idle(8);

    check(q16.size() == 0, "R3 all delivered", q16.size(), 0);
    check(q32.size() == 0, "R8 R3 all delivered", q32.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule